// File: doc/BRIEF.md
# Activity-Driven Pacing Interval Adapter

This block turns a quantized body-activity level into the pacing interval, in milliseconds, that a pulse generator uses for its next cycle. Each of seven activity codes maps to a target interval between the lower-rate interval (the longest interval allowed) and the upper-rate interval (the shortest). The block then moves the working interval toward that target one millisecond at a time. An accumulator advanced by a 1 ms tick sets the pace of each step.

Shortening the interval (rate rising) runs at a speed that would cover the whole lower-to-upper span in the reaction time. Lengthening it (rate falling) runs at a speed that would cover the same span in the recovery time. Activity at or below a programmable threshold leaves the target at the lower-rate interval. The target is derived again only when the sensed level differs from the stored one. The pulse generator sees a held copy of the working interval, which is refreshed only when it raises an update strobe.

Top module: `act_rate_adapter`

## Requirements
- R1: On the first clock edge after the internal reset ends, the stored level becomes very low (code 0), the target and working interval are loaded with the lower-rate interval, and the output shows the lower-rate interval.
- R2: The target is recomputed only in a cycle where the activity input differs from the stored level, and the stored level then takes the input's value. A change of threshold or limits with the level unchanged leaves the target as it was.
- R3: Level codes run 0 (very low), 1 (low), 2 (medium-low), 3 (medium), 4 (medium-high), 5 (high), 6 (very high); code 7 counts as 6. A level L above the threshold gives the target lri - floor((lri - uri) * L / 6).
- R4: With lri = 1000, uri = 500 and a threshold below 3, a medium level (3) brings the interval to 750 ms and it stays there.
- R5: While the working interval is longer than the target, each tick adds (lri - uri) to an accumulator. When the sum reaches the reaction time, the interval drops by 1 ms and the reaction time is subtracted, so after n ticks from rest the interval has dropped by floor(n * (lri - uri) / react). The accumulator restarts from zero when the direction changes or the target is reached.
- R6: While the working interval is shorter than the target, the same scheme applies with the recovery time, and the interval grows by 1 ms per step.
- R7: The working interval, and so the output, stays within [uri, lri] of the previous cycle, and is pulled inside at once when either limit moves past it.
- R8: The output changes only on the clock edge that samples the update strobe high, when it takes the working interval; otherwise it holds.
- R9: A level at or below the threshold gives the target lri.
- R10: The working interval does not move on cycles where the tick is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| upd_strobe | input | 1 | Pulse generator requests a fresh interval |
| act_level | input | 3 | Quantized activity level code |
| act_thresh | input | 3 | Level that must be exceeded to raise the rate |
| lri_ms | input | IW | Lower-rate interval, ms (longest) |
| uri_ms | input | IW | Upper-rate interval, ms (shortest) |
| react_ms | input | TW | Reaction time, ms |
| recov_ms | input | TW | Recovery time, ms |
| interval_ms | output | IW | Held pacing interval, ms |

## Verification
A level change is registered one edge after it is applied, so the bench leaves one idle cycle before it starts ticking. The working interval then moves on each edge that samples the tick high. The output copies it on the edge that samples the strobe, and the bench reads it at the falling edge after that. Step counts are therefore counted from the first tick edge after the idle cycle, and the expected values come from floor arithmetic on those counts. For the level sweep, the bench ticks long enough for the slowest full-span move before it strobes.

// File: rtl/act_rate_pkg.sv
package act_rate_pkg;
  localparam logic [2:0] LVL_VLOW  = 3'd0;
  localparam logic [2:0] LVL_VHIGH = 3'd6;
  localparam int unsigned LVL_STEPS = 6;

  typedef enum logic [1:0] {
    SLEW_HOLD = 2'd0,
    SLEW_DN   = 2'd1,
    SLEW_UP   = 2'd2
  } slew_dir_e;
endpackage

// File: rtl/rate_target_map.sv
module rate_target_map
  import act_rate_pkg::*;
#(
  parameter int IW = 12
) (
  input  logic [2:0]    lvl_i,
  input  logic [2:0]    thresh_i,
  input  logic [IW-1:0] lri_i,
  input  logic [IW-1:0] uri_i,
  output logic [IW-1:0] target_o
);
  localparam int PW = IW + 3;

  logic [2:0]    lvl_sat;
  logic [IW-1:0] span;
  logic [PW-1:0] prod;
  logic [IW-1:0] quot;

  always_comb begin
    lvl_sat  = (lvl_i > LVL_VHIGH) ? LVL_VHIGH : lvl_i;
    span     = lri_i - uri_i;
    prod     = PW'(span) * PW'(lvl_sat);
    quot     = IW'(prod / PW'(LVL_STEPS));
    target_o = (lvl_sat > thresh_i) ? (lri_i - quot) : lri_i;
  end
endmodule

// File: rtl/interval_slewer.sv
module interval_slewer
  import act_rate_pkg::*;
#(
  parameter int IW = 12,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_i,
  input  logic          tick_i,
  input  logic [IW-1:0] target_i,
  input  logic [IW-1:0] lri_i,
  input  logic [IW-1:0] uri_i,
  input  logic [TW-1:0] react_i,
  input  logic [TW-1:0] recov_i,
  output logic [IW-1:0] cur_o
);
  localparam int AW = TW + 1;

  logic [IW-1:0] cur_q, cur_n;
  logic [AW-1:0] acc_q, acc_n;
  slew_dir_e     dir_q, dir_n;
  logic [AW-1:0] span_ext, base_dn, base_up, sum_dn, sum_up;
  logic [IW-1:0] stepped;

  always_comb begin
    span_ext = AW'(lri_i - uri_i);
    base_dn  = (dir_q == SLEW_DN) ? acc_q : '0;
    base_up  = (dir_q == SLEW_UP) ? acc_q : '0;
    sum_dn   = base_dn + span_ext;
    sum_up   = base_up + span_ext;
    stepped  = cur_q;
    acc_n    = acc_q;
    dir_n    = dir_q;
    if (init_i) begin
      stepped = lri_i;
      acc_n   = '0;
      dir_n   = SLEW_HOLD;
    end else if (tick_i) begin
      if (cur_q > target_i) begin
        dir_n = SLEW_DN;
        if (sum_dn >= AW'(react_i)) begin
          stepped = cur_q - 1'b1;
          acc_n   = sum_dn - AW'(react_i);
        end else begin
          acc_n = sum_dn;
        end
      end else if (cur_q < target_i) begin
        dir_n = SLEW_UP;
        if (sum_up >= AW'(recov_i)) begin
          stepped = cur_q + 1'b1;
          acc_n   = sum_up - AW'(recov_i);
        end else begin
          acc_n = sum_up;
        end
      end else begin
        dir_n = SLEW_HOLD;
        acc_n = '0;
      end
    end
    if (stepped > lri_i)      cur_n = lri_i;
    else if (stepped < uri_i) cur_n = uri_i;
    else                      cur_n = stepped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      acc_q <= '0;
      dir_q <= SLEW_HOLD;
    end else begin
      cur_q <= cur_n;
      acc_q <= acc_n;
      dir_q <= dir_n;
    end
  end

  assign cur_o = cur_q;

  p_no_tick_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !tick_i && $stable(lri_i) && $stable(uri_i)) |=> $stable(cur_q));

  p_unit_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && tick_i && $stable(lri_i) && $stable(uri_i))
    |=> ((cur_q == $past(cur_q)) || (cur_q == $past(cur_q) + 1'b1) ||
         (cur_q + 1'b1 == $past(cur_q))));

  p_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !init_i |=> ((cur_q <= $past(lri_i)) && (cur_q >= $past(uri_i))));
endmodule

// File: rtl/interval_hold.sv
module interval_hold #(
  parameter int IW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_i,
  input  logic          strobe_i,
  input  logic [IW-1:0] lri_i,
  input  logic [IW-1:0] cur_i,
  output logic [IW-1:0] out_o
);
  logic [IW-1:0] out_q, out_n;

  always_comb begin
    out_n = out_q;
    if (init_i)        out_n = lri_i;
    else if (strobe_i) out_n = cur_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_n;
  end

  assign out_o = out_q;

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !strobe_i) |=> $stable(out_q));

  p_init_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (out_q == $past(lri_i)));
endmodule

// File: rtl/act_rate_adapter.sv
module act_rate_adapter
  import act_rate_pkg::*;
#(
  parameter int IW = 12,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_ms,
  input  logic          upd_strobe,
  input  logic [2:0]    act_level,
  input  logic [2:0]    act_thresh,
  input  logic [IW-1:0] lri_ms,
  input  logic [IW-1:0] uri_ms,
  input  logic [TW-1:0] react_ms,
  input  logic [TW-1:0] recov_ms,
  output logic [IW-1:0] interval_ms
);
  logic          rst_meta, rst_i;
  logic          init_q;
  logic          init;
  logic [2:0]    lvl_q, lvl_n;
  logic [IW-1:0] tgt_q, tgt_n;
  logic [IW-1:0] map_tgt;
  logic [IW-1:0] cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  assign init = !init_q;

  rate_target_map #(.IW(IW)) u_map (
    .lvl_i    (act_level),
    .thresh_i (act_thresh),
    .lri_i    (lri_ms),
    .uri_i    (uri_ms),
    .target_o (map_tgt)
  );

  always_comb begin
    lvl_n = lvl_q;
    tgt_n = tgt_q;
    if (init) begin
      lvl_n = LVL_VLOW;
      tgt_n = lri_ms;
    end else if (act_level != lvl_q) begin
      lvl_n = act_level;
      tgt_n = map_tgt;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      init_q <= 1'b0;
      lvl_q  <= LVL_VLOW;
      tgt_q  <= '0;
    end else begin
      init_q <= 1'b1;
      lvl_q  <= lvl_n;
      tgt_q  <= tgt_n;
    end
  end

  interval_slewer #(.IW(IW), .TW(TW)) u_slew (
    .clk      (clk),
    .rst_n    (rst_i),
    .init_i   (init),
    .tick_i   (tick_ms),
    .target_i (tgt_q),
    .lri_i    (lri_ms),
    .uri_i    (uri_ms),
    .react_i  (react_ms),
    .recov_i  (recov_ms),
    .cur_o    (cur)
  );

  interval_hold #(.IW(IW)) u_hold (
    .clk      (clk),
    .rst_n    (rst_i),
    .init_i   (init),
    .strobe_i (upd_strobe),
    .lri_i    (lri_ms),
    .cur_i    (cur),
    .out_o    (interval_ms)
  );

  p_level_gate_r2: assert property (@(posedge clk) disable iff (!rst_i)
    (!init && (act_level == lvl_q)) |=> $stable(tgt_q));

  p_level_track_r2: assert property (@(posedge clk) disable iff (!rst_i)
    !init |=> (lvl_q == $past(act_level)));
endmodule

// File: tb/tb_act_rate_adapter.sv
module tb_act_rate_adapter;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 12;
  localparam int TW = 16;
  localparam int WD_LIMIT = 190000;

  logic          clk;
  logic          rst_n;
  logic          tick_ms;
  logic          upd_strobe;
  logic [2:0]    act_level;
  logic [2:0]    act_thresh;
  logic [IW-1:0] lri_ms;
  logic [IW-1:0] uri_ms;
  logic [TW-1:0] react_ms;
  logic [TW-1:0] recov_ms;
  logic [IW-1:0] interval_ms;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  act_rate_adapter #(.IW(IW), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .upd_strobe(upd_strobe),
    .act_level(act_level), .act_thresh(act_thresh), .lri_ms(lri_ms),
    .uri_ms(uri_ms), .react_ms(react_ms), .recov_ms(recov_ms),
    .interval_ms(interval_ms)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WD_LIMIT) begin
      failures = failures + 1;
      $display("FAIL watchdog expired actual=%0d cycles expected=<%0d", cycles, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_ticks(input int n);
    tick_ms = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
    tick_ms = 1'b0;
  endtask

  task automatic set_level(input int l);
    act_level = 3'(l);
    @(negedge clk);
  endtask

  task automatic strobe_read(output int v);
    upd_strobe = 1'b1;
    @(negedge clk);
    upd_strobe = 1'b0;
    v = int'(interval_ms);
  endtask

  initial begin
    int v;
    int exp;
    rst_n = 1'b0; tick_ms = 1'b0; upd_strobe = 1'b0;
    act_level = 3'd0; act_thresh = 3'd0;
    lri_ms = 12'd1000; uri_ms = 12'd500;
    react_ms = 16'd500; recov_ms = 16'd1000;
    idle(3);
    rst_n = 1'b1;
    idle(5);
    // R1: reset state shows the lower-rate interval
    chk("R1 reset interval", int'(interval_ms), 1000);

    // R5: 100 ticks at one step per tick
    set_level(3);
    run_ticks(100);
    strobe_read(v); chk("R5 shorten 100 ticks", v, 900);
    // R10: no tick, no movement
    idle(50);
    strobe_read(v); chk("R10 no tick hold", v, 900);
    // R4: medium settles at 750
    run_ticks(150);
    strobe_read(v); chk("R4 medium reaches 750", v, 750);
    run_ticks(500);
    strobe_read(v); chk("R4 medium stays 750", v, 750);

    // R8: output held without strobe; R6: lengthen at half speed
    set_level(0);
    run_ticks(100);
    chk("R8 held without strobe", int'(interval_ms), 750);
    strobe_read(v); chk("R6 lengthen 100 ticks", v, 800);
    run_ticks(400);
    strobe_read(v); chk("R6 back to lri", v, 1000);

    // R5: fractional rate without drift
    react_ms = 16'd700;
    set_level(3);
    run_ticks(70);
    strobe_read(v); chk("R5 fractional 70 ticks", v, 1000 - (70 * 500) / 700);
    run_ticks(400);
    strobe_read(v); chk("R5 fractional settles", v, 750);
    react_ms = 16'd500;

    // R2: threshold change with same level does not recompute
    act_thresh = 3'd6;
    idle(1);
    run_ticks(300);
    strobe_read(v); chk("R2 no recompute", v, 750);
    // R9: level at/below threshold targets lri
    set_level(4);
    run_ticks(600);
    strobe_read(v); chk("R9 below threshold", v, 1000);

    // R7: clamp to moved limits
    lri_ms = 12'd800;
    idle(3);
    strobe_read(v); chk("R7 clamp to lri", v, 800);
    lri_ms = 12'd1000;
    uri_ms = 12'd900;
    idle(3);
    strobe_read(v); chk("R7 clamp to uri", v, 900);
    uri_ms = 12'd500;
    idle(1);
    run_ticks(250);
    strobe_read(v); chk("R6 recover after clamp", v, 1000);

    // R3 / R9 sweep over threshold and level
    for (int th = 0; th < 7; th++) begin
      for (int lv = 0; lv < 7; lv++) begin
        act_thresh = 3'(th);
        set_level(lv);
        run_ticks(1100);
        strobe_read(v);
        exp = (lv > th) ? 1000 - (500 * lv) / 6 : 1000;
        chk((lv > th) ? "R3 sweep mapped" : "R9 sweep at/below threshold", v, exp);
      end
    end

    // R3: code 7 behaves as very high
    act_thresh = 3'd0;
    set_level(7);
    run_ticks(600);
    strobe_read(v); chk("R3 code 7 saturates", v, 500);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule